// File: doc/BRIEF.md
# Serial Flash Status Auto-Poller

This block waits on a serial flash device for the host. Once started, it asks the neighbouring command sequencer for a status read and collects the returned status bytes. It then tests the collected word against a target value under a mask, and repeats after a programmable pause. A hit raises a sticky match flag. With auto-stop enabled the block returns to idle on the first hit. Without it, polling continues until the host aborts. The waveform on the flash pins belongs to the sequencer; this block only speaks to it through a request channel and a status-byte channel.

Both channels use valid/ready. The request channel carries the status length in bytes. `req_valid` rises only while a poll is running, and it stays high with `req_len` unchanged until `req_ready` is seen high at a clock edge. The status channel is driven by the sequencer. A byte moves on any edge where `st_valid` and `st_ready` are both high. `st_ready` is high only after a request has been accepted and until the expected number of bytes has arrived, so the sequencer must hold its byte while `st_ready` is low. Configuration inputs are captured at start and are ignored while a poll runs.

Top module: `status_poller`

## Requirements
- R1: After reset `busy`, `match_flag`, `req_valid` and `st_ready` are 0 and `status_word` is 0; no request is made until `start` is seen in idle.
- R2: A `start` in idle issues a request with `req_len` equal to `cfg_nbytes`, where 0 is read as 1 and values above 4 are read as 4; `req_valid` holds until `req_ready`.
- R3: The first status byte fills bits 7:0, the next bits 15:8 and so on; bytes that were not read are zero. `status_word` shows the new word in the second cycle after the last byte is accepted.
- R4: With `cfg_any_mode`=0 a match needs every bit set in the mask to equal the same bit of `cfg_match`; a zero mask always matches.
- R5: With `cfg_any_mode`=1 a match needs at least one bit set in the mask to equal its `cfg_match` bit; a zero mask never matches.
- R6: With interval N, exactly N+1 cycles with `req_valid` low lie between the cycle that accepts the last status byte and the next request.
- R7: With `cfg_auto_stop`=1 a match ends polling: `busy` falls in the same cycle that `match_flag` rises, and no further request follows.
- R8: With `cfg_auto_stop`=0 polling continues after a match, and every later match sets `match_flag` again. The flag stays set until `match_clr`, and a match in the same cycle as `match_clr` leaves the flag set.
- R9: An `abort` during a request or a status read lets that read finish (its bytes are accepted and `status_word` is updated) and then the block goes idle. An `abort` during the interval wait returns the block to idle on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin polling (taken in idle only) |
| abort | input | 1 | Stop polling |
| cfg_match | input | 32 | Target value |
| cfg_mask | input | 32 | Bits taking part in the test |
| cfg_interval | input | 16 | Cycles of pause between reads |
| cfg_nbytes | input | 3 | Status length in bytes (1 to 4) |
| cfg_any_mode | input | 1 | 0: all masked bits, 1: any masked bit |
| cfg_auto_stop | input | 1 | Stop at the first match |
| match_clr | input | 1 | Clear the match flag |
| req_valid | output | 1 | Status-read request valid |
| req_ready | input | 1 | Sequencer accepts the request |
| req_len | output | 3 | Bytes to read |
| st_valid | input | 1 | Status byte valid |
| st_ready | output | 1 | Poller accepts a status byte |
| st_data | input | 8 | Status byte |
| busy | output | 1 | Poll in progress |
| match_flag | output | 1 | Sticky match indication |
| status_word | output | 32 | Last status word read |

## Verification
Two pairs of events can land on the same edge. A host clear can coincide with the match evaluation, and an abort can coincide with the end of a read. The bench pulses `match_clr` in the evaluation cycle itself and expects the flag to read 1 afterwards; a clear pulsed alone in the wait that follows must read 0. For the abort, the bench raises `abort` just after a request is accepted and checks that the bytes are still taken, that `status_word` carries them, and that no new request appears.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic [2:0] {
    PS_IDLE,
    PS_REQ,
    PS_RECV,
    PS_EVAL,
    PS_WAIT
  } poll_state_e;
endpackage

// File: rtl/poll_collect.sv
module poll_collect #(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 4,
  parameter int CNT_W     = 3,
  localparam int WORD_W   = BYTE_W * MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic [BYTE_W-1:0] data,
  input  logic [CNT_W-1:0]  n_bytes,
  output logic              last_take,
  output logic [WORD_W-1:0] word
);
  logic [CNT_W-1:0] cnt;

  assign last_take = take && (cnt == n_bytes - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (take) cnt <= cnt + CNT_W'(1);
  end

  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              word[i*BYTE_W +: BYTE_W] <= '0;
      else if (clr)                            word[i*BYTE_W +: BYTE_W] <= '0;
      else if (take && cnt == CNT_W'(i))       word[i*BYTE_W +: BYTE_W] <= data;
    end
  end
endmodule

// File: rtl/poll_compare.sv
module poll_compare #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] status,
  input  logic [WORD_W-1:0] mask,
  input  logic [WORD_W-1:0] target,
  input  logic              any_mode,
  output logic              hit
);
  logic [WORD_W-1:0] agree;

  always_comb begin
    agree = mask & ~(status ^ target);
    if (any_mode) hit = |agree;
    else          hit = (agree == mask);
  end
endmodule

// File: rtl/poll_interval.sv
module poll_interval #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [IVL_W-1:0] len,
  output logic             done
);
  logic [IVL_W-1:0] cnt;

  assign done = (cnt == IVL_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= len;
    else if (run && cnt != '0)  cnt <= cnt - IVL_W'(1);
  end
endmodule

// File: rtl/status_poller.sv
module status_poller
  import poll_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 4,
  parameter int IVL_W     = 16,
  localparam int WORD_W   = BYTE_W * MAX_BYTES,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [WORD_W-1:0] cfg_match,
  input  logic [WORD_W-1:0] cfg_mask,
  input  logic [IVL_W-1:0]  cfg_interval,
  input  logic [CNT_W-1:0]  cfg_nbytes,
  input  logic              cfg_any_mode,
  input  logic              cfg_auto_stop,
  input  logic              match_clr,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [CNT_W-1:0]  req_len,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [BYTE_W-1:0] st_data,
  output logic              busy,
  output logic              match_flag,
  output logic [WORD_W-1:0] status_word
);
  poll_state_e state, nxt;

  logic [WORD_W-1:0] match_q, mask_q, word;
  logic [IVL_W-1:0]  ivl_q;
  logic [CNT_W-1:0]  len_q, len_clamp;
  logic              any_q, stop_q, abort_q;
  logic              hit, last_take, ivl_done, take;

  always_comb begin
    if (cfg_nbytes == '0)                         len_clamp = CNT_W'(1);
    else if (cfg_nbytes > CNT_W'(MAX_BYTES))      len_clamp = CNT_W'(MAX_BYTES);
    else                                          len_clamp = cfg_nbytes;
  end

  assign req_valid = (state == PS_REQ);
  assign st_ready  = (state == PS_RECV);
  assign busy      = (state != PS_IDLE);
  assign req_len   = len_q;
  assign take      = st_valid && st_ready;

  poll_collect #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_collect (
    .clk(clk), .rst_n(rst_n),
    .clr(req_valid && req_ready), .take(take), .data(st_data),
    .n_bytes(len_q), .last_take(last_take), .word(word)
  );

  poll_compare #(.WORD_W(WORD_W)) u_compare (
    .status(word), .mask(mask_q), .target(match_q), .any_mode(any_q), .hit(hit)
  );

  poll_interval #(.IVL_W(IVL_W)) u_interval (
    .clk(clk), .rst_n(rst_n),
    .load(state == PS_EVAL), .run(state == PS_WAIT), .len(ivl_q), .done(ivl_done)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      PS_IDLE: if (start) nxt = PS_REQ;
      PS_REQ:  if (req_ready) nxt = PS_RECV;
      PS_RECV: if (last_take) nxt = PS_EVAL;
      PS_EVAL: begin
        if ((stop_q && hit) || abort || abort_q) nxt = PS_IDLE;
        else if (ivl_q == '0)                    nxt = PS_REQ;
        else                                     nxt = PS_WAIT;
      end
      PS_WAIT: begin
        if (abort)         nxt = PS_IDLE;
        else if (ivl_done) nxt = PS_REQ;
      end
      default: nxt = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PS_IDLE;
    else        state <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      mask_q  <= '0;
      ivl_q   <= '0;
      len_q   <= CNT_W'(1);
      any_q   <= 1'b0;
      stop_q  <= 1'b0;
    end else if (state == PS_IDLE && start) begin
      match_q <= cfg_match;
      mask_q  <= cfg_mask;
      ivl_q   <= cfg_interval;
      len_q   <= len_clamp;
      any_q   <= cfg_any_mode;
      stop_q  <= cfg_auto_stop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 abort_q <= 1'b0;
    else if (state == PS_EVAL || state == PS_IDLE)
                                abort_q <= 1'b0;
    else if (abort && (state == PS_REQ || state == PS_RECV))
                                abort_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_flag  <= 1'b0;
      status_word <= '0;
    end else begin
      if (state == PS_EVAL) status_word <= word;
      if (state == PS_EVAL && hit) match_flag <= 1'b1;
      else if (match_clr)          match_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/status_poller_chk.sv
module status_poller_chk #(
  parameter int CNT_W     = 3,
  parameter int MAX_BYTES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             req_valid,
  input logic             req_ready,
  input logic [CNT_W-1:0] req_len,
  input logic             st_ready,
  input logic             match_flag,
  input logic             match_clr,
  input logic             stop_q
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!req_valid && !st_ready));

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_len)));

  assert_len_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len >= CNT_W'(1) && req_len <= CNT_W'(MAX_BYTES)));

  assert_chan_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && st_ready));

  assert_auto_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(match_flag) && stop_q) |-> !busy);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !match_clr) |=> match_flag);
endmodule

bind status_poller status_poller_chk #(.CNT_W(CNT_W), .MAX_BYTES(MAX_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
  .req_len(req_len), .st_ready(st_ready), .match_flag(match_flag),
  .match_clr(match_clr), .stop_q(stop_q)
);

// File: tb/test_status_poller.sv
module test_status_poller;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 0, abort = 0, match_clr = 0;
  logic [31:0] cfg_match = 0, cfg_mask = 0;
  logic [15:0] cfg_interval = 0;
  logic [2:0]  cfg_nbytes = 3'd1;
  logic        cfg_any_mode = 0, cfg_auto_stop = 0;
  logic        req_valid, req_ready = 0;
  logic [2:0]  req_len;
  logic        st_valid = 0, st_ready;
  logic [7:0]  st_data = 0;
  logic        busy, match_flag;
  logic [31:0] status_word;

  int checks = 0, errors = 0, cycles = 0;
  logic [2:0] seen_len;
  bit finished = 0;

  always #2.5 clk = ~clk;

  status_poller i_status_poller (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .cfg_match(cfg_match), .cfg_mask(cfg_mask), .cfg_interval(cfg_interval),
    .cfg_nbytes(cfg_nbytes), .cfg_any_mode(cfg_any_mode), .cfg_auto_stop(cfg_auto_stop),
    .match_clr(match_clr), .req_valid(req_valid), .req_ready(req_ready), .req_len(req_len),
    .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data),
    .busy(busy), .match_flag(match_flag), .status_word(status_word)
  );

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      report();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic setup(input logic [31:0] m, input logic [31:0] k, input logic [15:0] ivl,
                       input logic [2:0] nb, input logic anym, input logic stp);
    cfg_match = m; cfg_mask = k; cfg_interval = ivl;
    cfg_nbytes = nb; cfg_any_mode = anym; cfg_auto_stop = stp;
    match_clr = 1; @(negedge clk); match_clr = 0;
    start = 1; @(negedge clk); start = 0;
  endtask

  // Accept one request, then feed n bytes LSB first; returns at the negedge of the evaluation cycle.
  task automatic serve(input logic [31:0] w, input int n, input bit abort_mid);
    while (!req_valid) @(negedge clk);
    seen_len = req_len;
    req_ready = 1; @(negedge clk); req_ready = 0;
    if (abort_mid) begin abort = 1; @(negedge clk); abort = 0; end
    for (int k = 0; k < n; k++) begin
      while (!st_ready) @(negedge clk);
      st_valid = 1; st_data = w[8*k +: 8];
      @(negedge clk);
    end
    st_valid = 0;
  endtask

  task automatic pulse_abort();
    abort = 1; @(negedge clk); abort = 0;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 flag", match_flag, 0);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 st_ready", st_ready, 0);
    chk("R1 status_word", status_word, 0);
    repeat (3) @(negedge clk);
    chk("R1 no request without start", req_valid, 0);
  endtask

  task automatic t_all_mode();
    setup(32'h0, 32'h1, 16'd0, 3'd1, 1'b0, 1'b1);
    chk("R2 request after start", req_valid, 1);
    serve(32'h03, 1, 0); @(negedge clk);
    chk("R4 busy bit set: no match", match_flag, 0);
    chk("R4 still busy", busy, 1);
    chk("R3 status byte", status_word, 32'h03);
    serve(32'h02, 1, 0); @(negedge clk);
    chk("R4 masked bit equal: match", match_flag, 1);
    chk("R7 stopped on match", busy, 0);
    repeat (3) @(negedge clk);
    chk("R7 no further request", req_valid, 0);
    setup(32'h0, 32'h0, 16'd0, 3'd1, 1'b0, 1'b1);
    serve(32'hFF, 1, 0); @(negedge clk);
    chk("R4 zero mask matches", match_flag, 1);
  endtask

  task automatic t_layout();
    setup(32'h0, 32'h0, 16'd0, 3'd3, 1'b0, 1'b1);
    serve(32'hDDAABBCC, 3, 0); @(negedge clk);
    chk("R2 req_len 3", seen_len, 3);
    chk("R3 three bytes, top zero", status_word, 32'h00AABBCC);
    setup(32'h0, 32'h0, 16'd0, 3'd0, 1'b0, 1'b1);
    serve(32'h5A, 1, 0); @(negedge clk);
    chk("R2 zero length read as 1", seen_len, 1);
    setup(32'h0, 32'h0, 16'd0, 3'd7, 1'b0, 1'b1);
    serve(32'h12345678, 4, 0); @(negedge clk);
    chk("R2 length clamped to 4", seen_len, 4);
    chk("R3 four bytes", status_word, 32'h12345678);
  endtask

  task automatic t_any_mode();
    setup(32'h0A, 32'h0F, 16'd0, 3'd1, 1'b1, 1'b1);
    serve(32'h05, 1, 0); @(negedge clk);
    chk("R5 all masked bits differ: no match", match_flag, 0);
    serve(32'h04, 1, 0); @(negedge clk);
    chk("R5 one masked bit equal: match", match_flag, 1);
    chk("R7 stopped", busy, 0);
    setup(32'h0, 32'h0, 16'd20, 3'd1, 1'b1, 1'b1);
    serve(32'h00, 1, 0); @(negedge clk);
    chk("R5 zero mask never matches", match_flag, 0);
    chk("R5 still polling", busy, 1);
    pulse_abort();
    chk("R9 abort in wait idles", busy, 0);
  endtask

  task automatic t_interval(input int n);
    int g;
    setup(32'h0, 32'h0, n[15:0], 3'd1, 1'b1, 1'b0);
    serve(32'h00, 1, 0);
    g = 0;
    while (!req_valid && g < 100) begin @(negedge clk); g++; end
    chk("R6 gap cycles", g, n + 1);
    serve(32'h00, 1, 0);
    pulse_abort();
    chk("R9 abort at end of read idles", busy, 0);
  endtask

  task automatic t_continuous();
    setup(32'h00, 32'hFF, 16'd2, 3'd1, 1'b0, 1'b0);
    serve(32'h00, 1, 0); @(negedge clk);
    chk("R8 match without stop", match_flag, 1);
    chk("R8 keeps polling", busy, 1);
    match_clr = 1; @(negedge clk); match_clr = 0;
    chk("R8 host clear", match_flag, 0);
    serve(32'h01, 1, 0); @(negedge clk);
    chk("R8 no match leaves flag clear", match_flag, 0);
    serve(32'h00, 1, 0); @(negedge clk);
    chk("R8 set again on new match", match_flag, 1);
    serve(32'h00, 1, 0);
    match_clr = 1; @(negedge clk); match_clr = 0;
    chk("R8 match wins over same-cycle clear", match_flag, 1);
    match_clr = 1; @(negedge clk); match_clr = 0;
    chk("R8 lone clear in wait", match_flag, 0);
    pulse_abort();
    chk("R9 idle after abort", busy, 0);
  endtask

  task automatic t_abort();
    setup(32'h0, 32'h0, 16'd0, 3'd2, 1'b1, 1'b0);
    serve(32'h0000C3A5, 2, 1); @(negedge clk);
    chk("R9 read finished after abort", status_word, 32'h0000C3A5);
    chk("R9 idle after aborted read", busy, 0);
    repeat (3) @(negedge clk);
    chk("R9 no request after abort", req_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1; @(negedge clk);
    t_reset();
    t_all_mode();
    t_layout();
    t_any_mode();
    t_interval(0);
    t_interval(5);
    t_continuous();
    t_abort();
    repeat (2) @(negedge clk);
    report();
  end
endmodule